// File: doc/BRIEF.md
# CAS-before-RAS Refresh Scheduler

This block keeps a DRAM refreshed by running CAS-before-RAS cycles on a fixed schedule. An interval timer counts clocks and adds one owed refresh to a small backlog each time a period ends. While refreshes are owed, the block raises a request to the access controller. When the controller grants the bus, the block drives the strobes for one refresh and then hands the bus back with a one-cycle done pulse. The DRAM's own row counter chooses which row is refreshed, so the block drives no address.

Refreshes the controller had to put off during long page accesses stay in the backlog. The block runs them back to back while the grant stays high. A self-refresh command takes the block through a fixed bracket in one bus tenure: a refresh cycle, then RAS and CAS held low for at least the minimum self-refresh time, then a longer precharge after exit, then one more refresh cycle before the bus is released.

Top module: `cbr_refresh_sched`

## Requirements
- R1: While reset is asserted, and after it until the first request, `ref_req`, `ref_done`, `bus_own` and `sr_active` are 0 and `ras_n`, `ucas_n`, `lcas_n` and `we_n` are 1. Reset is released inside the block through a two-clock synchronizer.
- R2: Once reset is released, the first refresh becomes owed at the clock edge REF_INTERVAL_CLKS+2 after release, and one more at every REF_INTERVAL_CLKS edges after that. `ref_req` is high whenever the block is idle and a refresh or a self-refresh entry is owed.
- R3: The backlog of owed refreshes saturates at BACKLOG_MAX. If the grant is held high, the block runs exactly min(missed periods, BACKLOG_MAX) refresh cycles back to back and then drops `ref_req`.
- R4: In a refresh cycle, both CAS strobes are low for CSR_CLKS clocks before RAS falls. RAS then stays low for RAS_CLKS clocks, and CAS returns high after the first CHR_CLKS of them. `we_n` is high at all times.
- R5: RAS is high for at least RP_CLKS clocks between any two RAS-low periods. A normal refresh cycle is CSR_CLKS+RAS_CLKS+RP_CLKS clocks, from the clock edge that accepts the grant to the edge that returns the bus.
- R6: The strobes stay at their idle levels until the edge that samples `ref_req` and `ref_grant` both high. `bus_own` is high from that edge until the bus is returned. `ref_done` is high for exactly one cycle, the first cycle after return, and `ref_req` is low while the bus is owned.
- R7: A self-refresh request is latched from a one-cycle `sr_enter` and raises `ref_req`. Its grant starts one full refresh cycle, then CSR_CLKS clocks of CAS low with RAS high, then the hold state. In the hold state RAS and both CAS are low and `sr_active` is 1. No done pulse appears between these phases.
- R8: The hold state lasts at least SELF_MIN_CLKS clocks. An `sr_exit` seen earlier in the hold state is remembered and acted on once the minimum has elapsed. An `sr_exit` seen after the minimum ends the hold at that clock edge.
- R9: After the hold state, all strobes are high for RPS_CLKS clocks. One refresh cycle follows, and then the bus is released with a single `ref_done`.
- R10: Completing a self-refresh sequence clears the backlog and restarts the interval. The next refresh is owed exactly REF_INTERVAL_CLKS edges after the edge that released the bus.
- R11: `sr_enter` is ignored while a self-refresh sequence is in progress. `sr_exit` is ignored outside the hold state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_req | output | 1 | Refresh or self-refresh entry owed, block idle |
| ref_grant | input | 1 | Bus granted by the access controller |
| ref_done | output | 1 | One-cycle pulse when the bus is handed back |
| bus_own | output | 1 | Block is driving the DRAM strobes |
| sr_enter | input | 1 | Request to enter self-refresh (pulse) |
| sr_exit | input | 1 | Request to leave self-refresh (pulse) |
| sr_active | output | 1 | DRAM held in self-refresh |
| ras_n | output | 1 | Row strobe, active low |
| ucas_n | output | 1 | Upper byte column strobe, active low |
| lcas_n | output | 1 | Lower byte column strobe, active low |
| we_n | output | 1 | Write enable, held high |

## Verification
The bench checks the strobes cycle by cycle against expected waveforms for a plain refresh and for both self-refresh brackets. A wrong setup or hold count, or a missing precharge, therefore shows up as a mismatched cycle. Backlog bursts are started right after known period boundaries with random gaps and grant delays. A counter that wraps instead of saturating, or one that loses a decrement, gives the wrong number of done pulses. An exit requested before the self-refresh minimum, and a stray exit issued before entry, show whether a design releases RAS too early or keeps an exit it should have dropped. The gap from the end of self-refresh to the next request shows whether the timer and backlog are restarted.

// File: rtl/cbr_pkg.sv
package cbr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CSU   = 3'd1,
    ST_RAS   = 3'd2,
    ST_PRE   = 3'd3,
    ST_HOLD  = 3'd4,
    ST_SRPRE = 3'd5
  } seq_st_e;

  typedef enum logic [1:0] {
    PH_NORM  = 2'd0,
    PH_ENTRY = 2'd1,
    PH_TOSR  = 2'd2,
    PH_POST  = 2'd3
  } seq_ph_e;
endpackage

// File: rtl/cbr_interval_timer.sv
module cbr_interval_timer #(
  parameter int INTERVAL = 1950
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic restart,
  output logic tick
);
  localparam int CW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
  localparam logic [CW-1:0] LAST = CW'(INTERVAL - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = !hold && !restart && (cnt_q == LAST);
    if (hold || restart || tick) cnt_d = '0;
    else                         cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/cbr_backlog.sv
module cbr_backlog #(
  parameter int MAX = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic take,
  input  logic clear,
  output logic pending,
  output logic [$clog2(MAX+1)-1:0] level
);
  localparam int LW = $clog2(MAX + 1);
  localparam logic [LW-1:0] LMAX = LW'(MAX);

  logic [LW-1:0] lvl_q, lvl_d;
  logic          inc, dec, en;

  always_comb begin
    dec = take && (lvl_q != '0);
    inc = tick && ((lvl_q != LMAX) || dec);
    en  = clear || inc || dec;
    if (clear)           lvl_d = '0;
    else if (inc && !dec) lvl_d = lvl_q + 1'b1;
    else if (dec && !inc) lvl_d = lvl_q - 1'b1;
    else                 lvl_d = lvl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  lvl_q <= '0;
    else if (en) lvl_q <= lvl_d;
  end

  assign pending = (lvl_q != '0);
  assign level   = lvl_q;
endmodule

// File: rtl/cbr_strobe_seq.sv
module cbr_strobe_seq
  import cbr_pkg::*;
#(
  parameter int CSR_CLKS      = 1,
  parameter int CHR_CLKS      = 2,
  parameter int RAS_CLKS      = 8,
  parameter int RP_CLKS       = 5,
  parameter int SELF_MIN_CLKS = 12500,
  parameter int RPS_CLKS      = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic start_sr,
  input  logic sr_exit,
  output logic busy,
  output logic in_sr,
  output logic sr_active,
  output logic fin_norm,
  output logic fin_sr,
  output logic ras_n,
  output logic cas_n,
  output logic done
);
  localparam int M1 = (CSR_CLKS > RAS_CLKS) ? CSR_CLKS : RAS_CLKS;
  localparam int M2 = (RP_CLKS > RPS_CLKS) ? RP_CLKS : RPS_CLKS;
  localparam int M3 = (M1 > M2) ? M1 : M2;
  localparam int MX = (M3 > SELF_MIN_CLKS) ? M3 : SELF_MIN_CLKS;
  localparam int TW = $clog2(MX + 1);
  localparam logic [TW-1:0] L_CSR  = TW'(CSR_CLKS - 1);
  localparam logic [TW-1:0] L_RAS  = TW'(RAS_CLKS - 1);
  localparam logic [TW-1:0] L_RP   = TW'(RP_CLKS - 1);
  localparam logic [TW-1:0] L_SELF = TW'(SELF_MIN_CLKS - 1);
  localparam logic [TW-1:0] L_RPS  = TW'(RPS_CLKS - 1);
  localparam logic [TW-1:0] N_CHR  = TW'(CHR_CLKS);

  seq_st_e       st_q, st_d;
  seq_ph_e       ph_q, ph_d;
  logic [TW-1:0] tc_q, tc_d;
  logic          ex_q, ex_d;
  logic          ras_q, cas_q, done_q;
  logic          ras_d, cas_d;

  always_comb begin
    st_d     = st_q;
    ph_d     = ph_q;
    tc_d     = tc_q;
    ex_d     = 1'b0;
    fin_norm = 1'b0;
    fin_sr   = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_d = ST_CSU;
          tc_d = '0;
          ph_d = start_sr ? PH_ENTRY : PH_NORM;
        end
      end
      ST_CSU: begin
        if (tc_q == L_CSR) begin
          tc_d = '0;
          st_d = (ph_q == PH_TOSR) ? ST_HOLD : ST_RAS;
        end else tc_d = tc_q + 1'b1;
      end
      ST_RAS: begin
        if (tc_q == L_RAS) begin
          tc_d = '0;
          st_d = ST_PRE;
        end else tc_d = tc_q + 1'b1;
      end
      ST_PRE: begin
        if (tc_q == L_RP) begin
          tc_d = '0;
          if (ph_q == PH_ENTRY) begin
            st_d = ST_CSU;
            ph_d = PH_TOSR;
          end else begin
            st_d     = ST_IDLE;
            fin_norm = (ph_q == PH_NORM);
            fin_sr   = (ph_q == PH_POST);
            ph_d     = PH_NORM;
          end
        end else tc_d = tc_q + 1'b1;
      end
      ST_HOLD: begin
        if (tc_q == L_SELF) begin
          if (ex_q || sr_exit) begin
            st_d = ST_SRPRE;
            tc_d = '0;
          end
        end else begin
          tc_d = tc_q + 1'b1;
          ex_d = ex_q || sr_exit;
        end
      end
      ST_SRPRE: begin
        if (tc_q == L_RPS) begin
          tc_d = '0;
          st_d = ST_CSU;
          ph_d = PH_POST;
        end else tc_d = tc_q + 1'b1;
      end
      default: begin
        st_d = ST_IDLE;
        ph_d = PH_NORM;
        tc_d = '0;
      end
    endcase
    ras_d = !((st_d == ST_RAS) || (st_d == ST_HOLD));
    cas_d = !((st_d == ST_CSU) || (st_d == ST_HOLD) ||
              ((st_d == ST_RAS) && (tc_d < N_CHR)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      ph_q   <= PH_NORM;
      tc_q   <= '0;
      ex_q   <= 1'b0;
      ras_q  <= 1'b1;
      cas_q  <= 1'b1;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      ph_q   <= ph_d;
      tc_q   <= tc_d;
      ex_q   <= ex_d;
      ras_q  <= ras_d;
      cas_q  <= cas_d;
      done_q <= fin_norm || fin_sr;
    end
  end

  assign busy      = (st_q != ST_IDLE);
  assign in_sr     = (ph_q != PH_NORM);
  assign sr_active = (st_q == ST_HOLD);
  assign ras_n     = ras_q;
  assign cas_n     = cas_q;
  assign done      = done_q;
endmodule

// File: rtl/cbr_refresh_sched.sv
module cbr_refresh_sched #(
  parameter int REF_INTERVAL_CLKS = 1950,
  parameter int BACKLOG_MAX       = 8,
  parameter int CSR_CLKS          = 1,
  parameter int CHR_CLKS          = 2,
  parameter int RAS_CLKS          = 8,
  parameter int RP_CLKS           = 5,
  parameter int SELF_MIN_CLKS     = 12500,
  parameter int RPS_CLKS          = 14
) (
  input  logic clk,
  input  logic rst_n,
  output logic ref_req,
  input  logic ref_grant,
  output logic ref_done,
  output logic bus_own,
  input  logic sr_enter,
  input  logic sr_exit,
  output logic sr_active,
  output logic ras_n,
  output logic ucas_n,
  output logic lcas_n,
  output logic we_n
);
  localparam int LW = $clog2(BACKLOG_MAX + 1);

  logic [1:0]    rs_q;
  logic          srst_n;
  logic          tick, pending, start;
  logic          busy, in_sr, fin_norm, fin_sr, cas_n;
  logic          pend_q, pend_d;
  logic [LW-1:0] bl_level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign srst_n = rs_q[1];

  cbr_interval_timer #(.INTERVAL(REF_INTERVAL_CLKS)) u_timer (
    .clk(clk), .rst_n(srst_n), .hold(in_sr), .restart(fin_sr), .tick(tick)
  );

  cbr_backlog #(.MAX(BACKLOG_MAX)) u_backlog (
    .clk(clk), .rst_n(srst_n), .tick(tick), .take(fin_norm), .clear(fin_sr),
    .pending(pending), .level(bl_level)
  );

  assign ref_req = !busy && (pending || pend_q);
  assign start   = ref_req && ref_grant;

  always_comb begin
    pend_d = (pend_q && !start) || (sr_enter && !in_sr && !(start && pend_q));
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) pend_q <= 1'b0;
    else         pend_q <= pend_d;
  end

  cbr_strobe_seq #(
    .CSR_CLKS(CSR_CLKS), .CHR_CLKS(CHR_CLKS), .RAS_CLKS(RAS_CLKS),
    .RP_CLKS(RP_CLKS), .SELF_MIN_CLKS(SELF_MIN_CLKS), .RPS_CLKS(RPS_CLKS)
  ) u_seq (
    .clk(clk), .rst_n(srst_n), .start(start), .start_sr(pend_q),
    .sr_exit(sr_exit), .busy(busy), .in_sr(in_sr), .sr_active(sr_active),
    .fin_norm(fin_norm), .fin_sr(fin_sr), .ras_n(ras_n), .cas_n(cas_n),
    .done(ref_done)
  );

  assign bus_own = busy;
  assign ucas_n  = cas_n;
  assign lcas_n  = cas_n;
  assign we_n    = 1'b1;
endmodule

// File: rtl/cbr_refresh_sched_chk.sv
module cbr_refresh_sched_chk #(
  parameter int RP_CLKS     = 5,
  parameter int BACKLOG_MAX = 8
) (
  input logic clk,
  input logic rst_n,
  input logic ref_req,
  input logic ref_grant,
  input logic ref_done,
  input logic bus_own,
  input logic sr_active,
  input logic ras_n,
  input logic ucas_n,
  input logic lcas_n,
  input logic [$clog2(BACKLOG_MAX+1)-1:0] backlog
);
  localparam int HW = $clog2(RP_CLKS + 2);
  localparam logic [HW-1:0] HSAT = HW'(RP_CLKS + 1);
  localparam logic [HW-1:0] HMIN = HW'(RP_CLKS);
  localparam int LW = $clog2(BACKLOG_MAX + 1);
  localparam logic [LW-1:0] BMAX = LW'(BACKLOG_MAX);

  logic [HW-1:0] hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hi_q <= HSAT;
    else if (!ras_n) hi_q <= '0;
    else if (hi_q != HSAT) hi_q <= hi_q + 1'b1;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) backlog <= BMAX); // R3
  AST_CAS_LEADS_RAS: assert property (@(posedge clk) disable iff (!rst_n) $fell(ras_n) |-> $past(!ucas_n && !lcas_n)); // R4
  AST_RAS_PRECHARGE: assert property (@(posedge clk) disable iff (!rst_n) $fell(ras_n) |-> hi_q >= HMIN); // R5
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) ref_done |=> !ref_done); // R6
  AST_DONE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n) ref_done |-> !bus_own); // R6
  AST_IDLE_STROBES: assert property (@(posedge clk) disable iff (!rst_n) !bus_own |-> (ras_n && ucas_n && lcas_n)); // R6
  AST_GRANTED_START: assert property (@(posedge clk) disable iff (!rst_n) $rose(bus_own) |-> $past(ref_grant && ref_req)); // R6
  AST_NO_REQ_OWNED: assert property (@(posedge clk) disable iff (!rst_n) bus_own |-> !ref_req); // R6
  AST_SR_STROBES_LOW: assert property (@(posedge clk) disable iff (!rst_n) sr_active |-> (!ras_n && !ucas_n && !lcas_n && bus_own)); // R7
endmodule

bind cbr_refresh_sched cbr_refresh_sched_chk #(
  .RP_CLKS(RP_CLKS), .BACKLOG_MAX(BACKLOG_MAX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_req(ref_req), .ref_grant(ref_grant),
  .ref_done(ref_done), .bus_own(bus_own), .sr_active(sr_active),
  .ras_n(ras_n), .ucas_n(ucas_n), .lcas_n(lcas_n), .backlog(bl_level)
);

// File: tb/sim_cbr_refresh_sched.sv
`timescale 1ns/1ps
module sim_cbr_refresh_sched;
  localparam int IVL  = 200;
  localparam int BMAX = 8;
  localparam int CSR  = 1;
  localparam int CHR  = 2;
  localparam int RAS  = 5;
  localparam int RP   = 3;
  localparam int SMIN = 30;
  localparam int RPS  = 6;
  localparam int LCYC = CSR + RAS + RP;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_grant = 1'b0, sr_enter = 1'b0, sr_exit = 1'b0;
  logic ref_req, ref_done, bus_own, sr_active, ras_n, ucas_n, lcas_n, we_n;
  int   n_checks = 0, n_fail = 0, cyc = 0, hi_run = 0;
  bit   finished = 1'b0;

  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  cbr_refresh_sched #(
    .REF_INTERVAL_CLKS(IVL), .BACKLOG_MAX(BMAX), .CSR_CLKS(CSR),
    .CHR_CLKS(CHR), .RAS_CLKS(RAS), .RP_CLKS(RP),
    .SELF_MIN_CLKS(SMIN), .RPS_CLKS(RPS)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .ref_req(ref_req), .ref_grant(ref_grant),
    .ref_done(ref_done), .bus_own(bus_own), .sr_enter(sr_enter),
    .sr_exit(sr_exit), .sr_active(sr_active), .ras_n(ras_n),
    .ucas_n(ucas_n), .lcas_n(lcas_n), .we_n(we_n)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at cyc %0d", req, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  endtask

  // expected {ras, cas, own, done} of a plain refresh, j clocks after the grant edge
  function automatic logic [3:0] exp_norm(int j);
    logic ras, cas;
    ras = !((j >= CSR) && (j < CSR + RAS));
    cas = !((j < CSR) || ((j >= CSR) && (j < CSR + CHR)));
    if (j >= LCYC) return 4'b1101;
    return {ras, cas, 1'b1, 1'b0};
  endfunction

  // expected {ras, cas, own, done, sr_active} of a self-refresh bracket with hold h
  function automatic logic [4:0] exp_sr(int j, int h);
    int a, b, c, d, e;
    logic [3:0] n;
    a = LCYC; b = a + CSR; c = b + h; d = c + RPS; e = d + LCYC;
    if (j < a)  begin n = exp_norm(j); return {n[3:1], 1'b0, 1'b0}; end
    if (j < b)  return 5'b10100;
    if (j < c)  return 5'b00101;
    if (j < d)  return 5'b11100;
    if (j < e)  begin n = exp_norm(j - d); return {n, 1'b0}; end
    return 5'b11010;
  endfunction

  function automatic int tick_cyc(int m);
    return IVL + 2 + (m - 1) * IVL;
  endfunction

  function automatic int exp_burst(int k);
    return (k > BMAX) ? BMAX : k;
  endfunction

  // generic strobe rules while owned
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (bus_own) check("R4 we_n high", {7'd0, we_n}, 8'd1);
      if (!ras_n && hi_run > 0) begin
        check("R5 precharge before RAS", {7'd0, hi_run >= RP}, 8'd1);
        check("R4 CAS low before RAS", {6'd0, ucas_n, lcas_n}, 8'd0);
      end
      hi_run = ras_n ? hi_run + 1 : 0;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    finish_run();
  end

  task automatic run_sr(int exit_at, bit early, string tag);
    int  h, e;
    logic [4:0] x;
    @(negedge clk); sr_enter = 1'b1;
    @(negedge clk); sr_enter = 1'b0;
    check({tag, " R7 req after enter"}, {7'd0, ref_req}, 8'd1);
    if (!early) begin
      sr_exit = 1'b1; // ignored: not in hold (R11)
      @(negedge clk); sr_exit = 1'b0;
    end
    ref_grant = 1'b1;
    h = early ? SMIN : exit_at + 1;
    e = LCYC + CSR + h + RPS + LCYC;
    for (int j = 0; j <= e; j++) begin
      @(negedge clk);
      if (j == 0) ref_grant = 1'b0;
      sr_exit = 1'b0;
      sr_enter = 1'b0;
      x = exp_sr(j, h);
      check({tag, " R7 R8 R9 bracket"},
            {2'd0, ras_n, ucas_n, lcas_n, bus_own, ref_done, sr_active},
            {2'd0, x[4], x[3], x[3], x[2], x[1], x[0]});
      if (j == LCYC + CSR + 2) sr_enter = 1'b1; // R11 ignored during sequence
      if (j == LCYC + CSR + exit_at) sr_exit = 1'b1;
    end
    check({tag, " R10 R11 no req after bracket"}, {7'd0, ref_req}, 8'd0);
  endtask

  initial begin
    int m_next, k, d, cnt, ce, budget;
    void'($urandom(32'h5EED1234));
    repeat (5) @(negedge clk);
    check("R1 reset outputs",
          {ref_req, ref_done, bus_own, ras_n, ucas_n, lcas_n, we_n, sr_active},
          8'b00011110);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 after release",
          {ref_req, ref_done, bus_own, ras_n, ucas_n, lcas_n, we_n, sr_active},
          8'b00011110);
    sr_exit = 1'b1;  // R11 stray exit while idle
    @(negedge clk); sr_exit = 1'b0;

    while (cyc < IVL + 1) @(negedge clk);
    check("R2 no req before interval", {7'd0, ref_req}, 8'd0);
    @(negedge clk);
    check("R2 req at interval", {7'd0, ref_req}, 8'd1);
    repeat (5) @(negedge clk);
    check("R6 idle strobes without grant",
          {4'd0, bus_own, ras_n, ucas_n, lcas_n}, 8'b0111);
    check("R6 req held without grant", {7'd0, ref_req}, 8'd1);
    ref_grant = 1'b1;
    for (int j = 0; j <= LCYC; j++) begin
      logic [3:0] x;
      @(negedge clk);
      if (j == 0) begin
        ref_grant = 1'b0;
        check("R6 req low while owned", {7'd0, ref_req}, 8'd0);
      end
      x = exp_norm(j);
      check("R4 R5 R6 refresh cycle",
            {3'd0, ras_n, ucas_n, lcas_n, bus_own, ref_done},
            {3'd0, x[3], x[2], x[2], x[1], x[0]});
    end
    check("R6 req low after single refresh", {7'd0, ref_req}, 8'd0);

    m_next = 2;
    for (int it = 0; it < 6; it++) begin
      k = (it == 0) ? 11 : 1 + ($urandom % 10);
      d = $urandom % 16;
      while (cyc < tick_cyc(m_next + k - 1)) @(negedge clk);
      repeat (d) @(negedge clk);
      ref_grant = 1'b1;
      cnt = 0;
      budget = 0;
      while (budget < 150) begin
        @(negedge clk);
        budget++;
        if (ref_done) cnt++;
        if (ref_done && !ref_req) break;
      end
      ref_grant = 1'b0;
      check("R3 burst length", 8'(cnt), 8'(exp_burst(k)));
      m_next += k;
    end

    run_sr(5, 1'b1, "early-exit");
    ce = cyc;
    while (cyc < ce + IVL - 1) @(negedge clk);
    check("R10 no req before restarted interval", {7'd0, ref_req}, 8'd0);
    @(negedge clk);
    check("R10 req at restarted interval", {7'd0, ref_req}, 8'd1);
    run_sr(SMIN + 12, 1'b0, "late-exit");
    repeat (4) @(negedge clk);
    check("R10 backlog cleared", {7'd0, ref_req}, 8'd0);
    finish_run();
  end
endmodule